// File: doc/BRIEF.md
# Ethernet Low-Power Idle Entry and Wake Timers

This block decides when an Ethernet transmitter may signal low-power idle (LPI) to its PHY, and when it may return to normal transmission. It holds two programmable limits in one 32-bit control word. The first limit is a link qualification time in milliseconds. The link must stay up without a break for that long before LPI may be signalled, even when LPI is enabled and requested. The second limit is a wake time in microseconds. It starts when LPI signalling ends, and transmission stays held off until it has run out.

A free-running prescaler divides the core clock into microsecond and millisecond ticks, and both timers advance only on those ticks. A small sequencer moves between three states: active, signalling LPI, and waking. It drives a registered LPI-assert output and a registered transmit-resume-allowed output. Each time a wake period ends, it raises a sticky exit flag that software clears by reading it. Limits written while a count is running are compared against the count already reached, so the count is not restarted.

Top module: `eee_idle_timers`

## Requirements
- R1: The control word carries the link qualification limit in bits 25:16 and the wake limit in bits 15:0. All other bits read as zero, and writes to them are ignored.
- R2: After reset, the qualification limit is 1000 ms and the wake limit is 0 µs. After reset, `lpi_assert` is 0, `tx_resume_ok` is 1 and `lpi_exit_flag` is 0.
- R3: A microsecond tick occurs every CLKS_PER_US clocks, and a millisecond tick every US_PER_MS microsecond ticks. Both timers advance only on these ticks.
- R4: `lpi_assert` rises only when `lpi_en`, `tx_lpi_req` and `link_up` are all high and the link has been up continuously for the programmed number of millisecond ticks.
- R5: While `lpi_assert` is high, `tx_resume_ok` is low. After LPI ends, `tx_resume_ok` returns high only once the programmed number of microsecond ticks has elapsed.
- R6: `lpi_exit_flag` sets when a wake period expires. It stays set until a pulse on `exit_flag_rd` clears it, and a set in the same cycle takes precedence over the clear.
- R7: A low `link_up` clears the qualification count. `lpi_assert` falls on the next clock, and a full new qualification period is needed before LPI can be signalled again.
- R8: With a wake limit of 0, `tx_resume_ok` rises one clock after `lpi_assert` falls, and `lpi_exit_flag` is still set.
- R9: A request that arrives during a wake period is held off until the wake period ends. LPI is then re-entered only if all entry conditions still hold.
- R10: Writing a new limit does not restart a running count. The new value is compared against the count already reached.
- R11: With `lpi_en` low, `lpi_assert` stays low whatever the request and link state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Write strobe for the control word |
| cfg_wr_data | input | 32 | Control word write data |
| cfg_rd_data | output | 32 | Control word readback |
| exit_flag_rd | input | 1 | Software read of the exit flag; clears it |
| lpi_en | input | 1 | LPI enable |
| link_up | input | 1 | PHY link status, high when up |
| tx_lpi_req | input | 1 | Transmitter request to enter LPI |
| lpi_assert | output | 1 | Signal LPI to the PHY |
| tx_resume_ok | output | 1 | Normal transmission allowed |
| lpi_exit_flag | output | 1 | Sticky flag: a wake period has expired |

## Verification
The bench measures the delay from link-up to LPI entry against a window derived from the tick periods. A design that ignores qualification, or counts clocks instead of ticks, lands outside that window. It pulls the link down during LPI and expects LPI to drop on the next clock and a full new qualification period to follow; a counter that only pauses on link loss would re-enter far too early. It raises a request in the middle of a wake period, and separately shortens the wake limit in the middle of a count. A sequencer that skips the wake lands before the window, and a timer that restarts on a write lands after it. It also checks the zero-wake edge, where transmission must resume exactly one clock after LPI falls with the flag still set.

// File: rtl/eee_idle_pkg.sv
package eee_idle_pkg;
  localparam int CTRL_W = 32;

  typedef enum logic [1:0] {
    ST_ACTIVE = 2'd0,
    ST_LPI    = 2'd1,
    ST_WAKE   = 2'd2
  } pm_state_e;
endpackage

// File: rtl/eee_tick_gen.sv
module eee_tick_gen #(
  parameter int CLKS_PER_US = 250,
  parameter int US_PER_MS   = 1000
) (
  input  logic clk,
  input  logic rst,
  output logic us_tick,
  output logic ms_tick
);
  localparam int UW = $clog2(CLKS_PER_US + 1);
  localparam int MW = $clog2(US_PER_MS + 1);
  localparam logic [UW-1:0] US_LAST = UW'(CLKS_PER_US - 1);
  localparam logic [MW-1:0] MS_LAST = MW'(US_PER_MS - 1);

  logic [UW-1:0] us_cnt;
  logic [MW-1:0] ms_cnt;

  assign us_tick = (us_cnt == US_LAST);
  assign ms_tick = us_tick && (ms_cnt == MS_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      us_cnt <= '0;
      ms_cnt <= '0;
    end else begin
      if (us_tick) us_cnt <= '0;
      else         us_cnt <= us_cnt + UW'(1);
      if (us_tick) begin
        if (ms_cnt == MS_LAST) ms_cnt <= '0;
        else                   ms_cnt <= ms_cnt + MW'(1);
      end
    end
  end

  generate
    if (CLKS_PER_US > 1) begin : g_spacing
      p_us_spacing_r3: assert property (@(posedge clk) disable iff (rst)
        us_tick |=> !us_tick);
    end
  endgenerate
endmodule

// File: rtl/eee_link_qual.sv
module eee_link_qual #(
  parameter int LST_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             link_up,
  input  logic             ms_tick,
  input  logic [LST_W-1:0] limit,
  output logic             qualified
);
  logic [LST_W-1:0] up_ms;

  always_ff @(posedge clk) begin
    if (rst || !link_up) begin
      up_ms     <= '0;
      qualified <= 1'b0;
    end else begin
      if (ms_tick && (up_ms < limit)) up_ms <= up_ms + LST_W'(1);
      qualified <= (up_ms >= limit);
    end
  end

  p_linkdown_clears_r7: assert property (@(posedge clk) disable iff (rst)
    !link_up |=> (!qualified && up_ms == '0));
endmodule

// File: rtl/eee_wake_timer.sv
module eee_wake_timer #(
  parameter int TWT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             us_tick,
  input  logic [TWT_W-1:0] limit,
  output logic             busy,
  output logic             done
);
  logic [TWT_W-1:0] wake_us;

  assign done = busy && (wake_us >= limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      wake_us <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      wake_us <= '0;
    end else if (done) begin
      busy    <= 1'b0;
    end else if (busy && us_tick && (wake_us != '1)) begin
      wake_us <= wake_us + TWT_W'(1);
    end
  end

  p_done_ends_wake_r5: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> !busy);
endmodule

// File: rtl/eee_idle_timers.sv
module eee_idle_timers
  import eee_idle_pkg::*;
#(
  parameter int CLKS_PER_US = 250,
  parameter int US_PER_MS   = 1000,
  parameter int LST_W       = 10,
  parameter int LST_LSB     = 16,
  parameter int TWT_W       = 16,
  parameter int LST_RST     = 1000,
  parameter int TWT_RST     = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr_en,
  input  logic [CTRL_W-1:0] cfg_wr_data,
  output logic [CTRL_W-1:0] cfg_rd_data,
  input  logic              exit_flag_rd,
  input  logic              lpi_en,
  input  logic              link_up,
  input  logic              tx_lpi_req,
  output logic              lpi_assert,
  output logic              tx_resume_ok,
  output logic              lpi_exit_flag
);
  localparam logic [CTRL_W-1:0] FIELD_MASK =
    ({{(CTRL_W-LST_W){1'b0}}, {LST_W{1'b1}}} << LST_LSB) |
    {{(CTRL_W-TWT_W){1'b0}}, {TWT_W{1'b1}}};

  logic [LST_W-1:0] lst_q;
  logic [TWT_W-1:0] twt_q;
  logic             us_tick, ms_tick;
  logic             qualified;
  logic             wake_start, wake_busy, wake_done;
  logic             want_lpi;
  pm_state_e        state, state_n;
  logic             unused_wr;

  assign unused_wr = ^(cfg_wr_data & ~FIELD_MASK);

  // control word
  always_ff @(posedge clk) begin
    if (rst) begin
      lst_q <= LST_W'(LST_RST);
      twt_q <= TWT_W'(TWT_RST);
    end else if (cfg_wr_en) begin
      lst_q <= cfg_wr_data[LST_LSB +: LST_W];
      twt_q <= cfg_wr_data[TWT_W-1:0];
    end
  end

  always_comb begin
    cfg_rd_data = '0;
    cfg_rd_data[LST_LSB +: LST_W] = lst_q;
    cfg_rd_data[TWT_W-1:0]        = twt_q;
  end

  eee_tick_gen #(.CLKS_PER_US(CLKS_PER_US), .US_PER_MS(US_PER_MS)) u_ticks (
    .clk(clk), .rst(rst), .us_tick(us_tick), .ms_tick(ms_tick)
  );

  eee_link_qual #(.LST_W(LST_W)) u_qual (
    .clk(clk), .rst(rst), .link_up(link_up), .ms_tick(ms_tick),
    .limit(lst_q), .qualified(qualified)
  );

  eee_wake_timer #(.TWT_W(TWT_W)) u_wake (
    .clk(clk), .rst(rst), .start(wake_start), .us_tick(us_tick),
    .limit(twt_q), .busy(wake_busy), .done(wake_done)
  );

  // power-state sequencer
  assign want_lpi   = lpi_en && tx_lpi_req && link_up && qualified;
  assign wake_start = (state == ST_LPI) && !want_lpi;

  always_comb begin
    state_n = state;
    unique case (state)
      ST_ACTIVE: if (want_lpi)  state_n = ST_LPI;
      ST_LPI:    if (!want_lpi) state_n = ST_WAKE;
      ST_WAKE:   if (wake_done) state_n = ST_ACTIVE;
      default:                  state_n = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_ACTIVE;
      lpi_assert    <= 1'b0;
      tx_resume_ok  <= 1'b1;
      lpi_exit_flag <= 1'b0;
    end else begin
      state        <= state_n;
      lpi_assert   <= (state_n == ST_LPI);
      tx_resume_ok <= (state_n == ST_ACTIVE);
      if (wake_done)         lpi_exit_flag <= 1'b1;
      else if (exit_flag_rd) lpi_exit_flag <= 1'b0;
    end
  end

  p_lpi_qualified_r4: assert property (@(posedge clk) disable iff (rst)
    lpi_assert |-> $past(qualified));

  p_lpi_needs_enable_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(lpi_assert) |-> $past(lpi_en));

  p_resume_after_wake_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_resume_ok) |-> $past(wake_done));

  p_flag_on_expiry_r6: assert property (@(posedge clk) disable iff (rst)
    wake_done |=> lpi_exit_flag);

  p_wake_holds_off_r9: assert property (@(posedge clk) disable iff (rst)
    (wake_busy && !wake_done) |=> !lpi_assert);
endmodule

// File: tb/eee_idle_timers_tb.sv
module eee_idle_timers_tb;
  localparam int CPU = 2;
  localparam int UPM = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr_en = 1'b0;
  logic [31:0] cfg_wr_data = '0;
  logic [31:0] cfg_rd_data;
  logic        exit_flag_rd = 1'b0;
  logic        lpi_en = 1'b0;
  logic        link_up = 1'b0;
  logic        tx_lpi_req = 1'b0;
  logic        lpi_assert, tx_resume_ok, lpi_exit_flag;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit ended = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  eee_idle_timers #(.CLKS_PER_US(CPU), .US_PER_MS(UPM)) u_dut (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .exit_flag_rd(exit_flag_rd), .lpi_en(lpi_en),
    .link_up(link_up), .tx_lpi_req(tx_lpi_req), .lpi_assert(lpi_assert),
    .tx_resume_ok(tx_resume_ok), .lpi_exit_flag(lpi_exit_flag)
  );

  // scoreboard of expected output edges: kind 0 = lpi_assert rise, 1 = tx_resume_ok rise
  typedef struct {
    int    kind;
    int    lo;
    int    hi;
    int    start;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push_exp(input int kind, input int lo, input int hi, input string tag);
    exp_t e;
    e.kind = kind; e.lo = lo; e.hi = hi; e.start = cyc; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk);
  endtask

  task automatic wr_cfg(input logic [31:0] d);
    cfg_wr_en = 1'b1; cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic clear_flag();
    exit_flag_rd = 1'b1;
    @(negedge clk);
    exit_flag_rd = 1'b0;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  // monitor: pops the front item when its edge shows up, or on deadline
  logic prev_lpi = 1'b0;
  logic prev_res = 1'b1;
  always @(negedge clk) begin
    if (!rst && exp_q.size() > 0) begin
      int el;
      bit hit;
      el  = cyc - exp_q[0].start;
      hit = (exp_q[0].kind == 0) ? (lpi_assert && !prev_lpi) : (tx_resume_ok && !prev_res);
      if (hit) begin
        chk(el >= exp_q[0].lo && el <= exp_q[0].hi, exp_q[0].tag, el, exp_q[0].lo);
        void'(exp_q.pop_front());
      end else if (el > exp_q[0].hi) begin
        chk(1'b0, {exp_q[0].tag, " (edge missing)"}, el, exp_q[0].hi);
        void'(exp_q.pop_front());
      end
    end
    prev_lpi = lpi_assert;
    prev_res = tx_resume_ok;
  end

  initial begin
    repeat (30000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R2 reset state
    chk(cfg_rd_data == 32'h03E8_0000, "R2 reset control word", cfg_rd_data, 32'h03E8_0000);
    chk(!lpi_assert && tx_resume_ok && !lpi_exit_flag, "R2 reset outputs",
        {lpi_assert, tx_resume_ok, lpi_exit_flag}, 3'b010);

    // R1 field layout, reserved bits dropped: qual 5 ms, wake 3 us
    wr_cfg(32'hFC05_0003);
    chk(cfg_rd_data == 32'h0005_0003, "R1 readback", cfg_rd_data, 32'h0005_0003);

    // R4/R3 entry after 5 ms ticks (8 clocks each) of continuous link
    lpi_en = 1'b1; tx_lpi_req = 1'b1; link_up = 1'b1;
    push_exp(0, 30, 44, "R4 qualification delay");
    drain();
    chk(lpi_assert && !tx_resume_ok, "R5 no transmit during LPI", tx_resume_ok, 0);

    // R11 enable low blocks LPI
    lpi_en = 1'b0;
    repeat (12) @(negedge clk);
    chk(!lpi_assert, "R11 enable low", lpi_assert, 0);
    clear_flag();
    lpi_en = 1'b1;
    push_exp(0, 1, 3, "R11 re-enable entry");
    drain();

    // R5 / R6 wake of 3 us, flag sticky until read
    tx_lpi_req = 1'b0;
    push_exp(1, 4, 10, "R5 wake delay");
    drain();
    chk(lpi_exit_flag, "R6 flag set on expiry", lpi_exit_flag, 1);
    repeat (5) @(negedge clk);
    chk(lpi_exit_flag, "R6 flag held", lpi_exit_flag, 1);
    clear_flag();
    chk(!lpi_exit_flag, "R6 flag cleared by read", lpi_exit_flag, 0);

    // R9 request during a 20 us wake
    wr_cfg(32'h0005_0014);
    tx_lpi_req = 1'b1;
    push_exp(0, 1, 3, "R9 entry");
    drain();
    tx_lpi_req = 1'b0;
    push_exp(1, 36, 46, "R9 wake completes first");
    push_exp(0, 37, 48, "R9 re-entry after wake");
    @(negedge clk);
    tx_lpi_req = 1'b1;
    repeat (20) @(negedge clk);
    chk(!lpi_assert, "R9 held off mid-wake", lpi_assert, 0);
    drain();
    clear_flag();

    // R10 shorten wake limit mid-count: no restart
    tx_lpi_req = 1'b0;
    push_exp(1, 9, 14, "R10 no restart on write");
    repeat (10) @(negedge clk);
    wr_cfg(32'h0005_0002);
    drain();
    clear_flag();

    // R8 zero wake time
    wr_cfg(32'h0005_0000);
    tx_lpi_req = 1'b1;
    push_exp(0, 1, 3, "R8 entry");
    drain();
    tx_lpi_req = 1'b0;
    @(negedge clk);
    chk(!lpi_assert && !tx_resume_ok, "R8 cycle after exit",
        {lpi_assert, tx_resume_ok}, 0);
    @(negedge clk);
    chk(tx_resume_ok, "R8 resume one clock later", tx_resume_ok, 1);
    chk(lpi_exit_flag, "R8 flag still set", lpi_exit_flag, 1);
    clear_flag();

    // R7 link loss
    tx_lpi_req = 1'b1;
    push_exp(0, 1, 3, "R7 entry");
    drain();
    link_up = 1'b0;
    @(negedge clk);
    chk(!lpi_assert, "R7 LPI drops on link loss", lpi_assert, 0);
    repeat (3) @(negedge clk);
    link_up = 1'b1;
    push_exp(0, 30, 44, "R7 full requalification");
    repeat (20) @(negedge clk);
    chk(!lpi_assert, "R7 no early re-entry", lpi_assert, 0);
    drain();

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule